// File: doc/BRIEF.md
# Set/Clear Interrupt Request Controller

This block gathers fourteen peripheral interrupt sources for a 68000-style processor. Each source owns one bit in a request register and one bit in an enable register. An extra bit in the enable register acts as a global gate. The block reports the most urgent pending level on a 3-bit active-low priority output.

Both registers use set/clear writes. Bit 15 of the written word chooses the operation. When bit 15 is 1, every bit that is 1 in data bits 14..0 is set. When bit 15 is 0, every bit that is 1 in the data is cleared. Bits that are 0 in the data are left alone. Software therefore never needs a read-modify-write to change one bit.

Each register has its own write port and its own read-back port. Hardware source pulses latch into the request register whatever the enable state. A pulse on the same bit as a software clear in the same cycle wins over the clear.

Top module: `irq_ctrl`

## Requirements
- R1: After reset both read-back ports read 0x0000 and `ipl_no` reads 3'b111, which is level 0.
- R2: A write whose bit 15 is 1 sets every register bit whose data bit is 1. All other bits keep their value. Bit 15 is never stored and reads back as 0.
- R3: A write whose bit 15 is 0 clears every register bit whose data bit is 1. All other bits keep their value. For example, 0x0020 written to the request register clears only request bit 5.
- R4: A 1 on `src_pulse_i[n]` (n ≠ 2) sets request bit n. The bit is visible on the read-back port one cycle later. It stays set until software clears it, whatever the enable bits hold.
- R5: Request bit 2 (software interrupt) has no hardware input: `src_pulse_i[2]` has no effect. Only a set write can raise that bit.
- R6: When a hardware pulse and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R7: Enable bit 14 is the master enable. While it is 0, `ipl_no` stays at 3'b111, whatever the request and enable bits hold.
- R8: The source bits map to levels as follows:
  - bits 0–2 → level 1
  - bit 3 → level 2
  - bits 4–6 → level 3
  - bits 7–10 → level 4
  - bits 11–12 → level 5
  - bit 13 → level 6
  
  Level 7 is never output.
- R9: `ipl_no` is the bitwise inverse of the highest level that has a bit set in both request and enable, with the master enable on. With no such bit the level is 0. The output is registered, so it reflects register contents one clock after they change.
- R10: The request register holds bits 0..13 only. Request read-back bits 14 and 15 always read 0, even after a set write of 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ena_wr_i | input | 1 | Write strobe for the enable register |
| ena_wdata_i | input | 16 | Set/clear word for the enable register |
| req_wr_i | input | 1 | Write strobe for the request register |
| req_wdata_i | input | 16 | Set/clear word for the request register |
| src_pulse_i | input | 14 | Hardware source pulses, one per request bit (bit 2 unused) |
| ena_rdata_o | output | 16 | Enable register read-back |
| req_rdata_o | output | 16 | Request register read-back |
| ipl_no | output | 3 | Active-low priority level to the processor |

## Verification
The hardest case to reach from the ports is a hardware pulse that lands in the same cycle as a software clear of that same bit. The other hard case is a high-level request that is masked while a lower one is enabled. Random traffic rarely lines these up. Directed sequences therefore drive the pulse and the clearing write in one cycle. They also build layered enable patterns with the master enable toggled. Around them, seeded random writes and sparse pulses run against a bench model of both registers and the level table.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned NUM_SRC  = 14;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned NUM_LVL  = 6;
  localparam int unsigned CTRL_BIT = 15;
  localparam int unsigned SOFT_BIT = 2;

  function automatic logic [LVL_W-1:0] src_level(int unsigned idx);
    logic [LVL_W-1:0] l;
    if (idx <= 2)       l = 3'd1;
    else if (idx == 3)  l = 3'd2;
    else if (idx <= 6)  l = 3'd3;
    else if (idx <= 10) l = 3'd4;
    else if (idx <= 12) l = 3'd5;
    else                l = 3'd6;
    return l;
  endfunction

  function automatic logic [NUM_SRC-1:0] level_mask(int unsigned lvl);
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++)
      if (int'(src_level(i)) == int'(lvl)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_sc_reg.sv
module irq_sc_reg
  import irq_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [W-1:0]      hw_set_i,
  output logic [W-1:0]      q_o
);
  logic [W-1:0] bits;
  logic [W-1:0] nxt;

  assign bits = wdata_i[W-1:0];

  always_comb begin
    nxt = q_o;
    if (wr_i) begin
      if (wdata_i[CTRL_BIT]) nxt = q_o | bits;
      else                   nxt = q_o & ~bits;
    end
    nxt = nxt | hw_set_i;  // hardware set beats a clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end

  p_set_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[CTRL_BIT]) |=> ((q_o & $past(bits)) == $past(bits)));

  p_clear_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[CTRL_BIT] && hw_set_i == '0) |=> ((q_o & $past(bits)) == '0));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((q_o & $past(hw_set_i)) == $past(hw_set_i)));

  p_latched_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && hw_set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
  import irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [NUM_LVL:1] hit;

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    localparam logic [NUM_SRC-1:0] MASK = level_mask(l);
    assign hit[l] = |(pend_i & MASK);
  end

  always_comb begin
    lvl_o = '0;
    for (int unsigned l = 1; l <= NUM_LVL; l++)
      if (hit[l]) lvl_o = LVL_W'(l);
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ena_wr_i,
  input  logic [DATA_W-1:0]  ena_wdata_i,
  input  logic               req_wr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  output logic [DATA_W-1:0]  ena_rdata_o,
  output logic [DATA_W-1:0]  req_rdata_o,
  output logic [LVL_W-1:0]   ipl_no
);
  localparam int unsigned MASTER_BIT = NUM_SRC;
  localparam logic [NUM_SRC-1:0] HW_MASK = ~(NUM_SRC'(1) << SOFT_BIT);

  logic [NUM_SRC:0]   ena_q;
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] pend;
  logic [LVL_W-1:0]   lvl;

  irq_sc_reg #(.W(NUM_SRC+1)) u_ena (
    .clk_i, .rst_ni, .wr_i(ena_wr_i), .wdata_i(ena_wdata_i),
    .hw_set_i('0), .q_o(ena_q)
  );

  irq_sc_reg #(.W(NUM_SRC)) u_req (
    .clk_i, .rst_ni, .wr_i(req_wr_i), .wdata_i(req_wdata_i),
    .hw_set_i(src_pulse_i & HW_MASK), .q_o(req_q)
  );

  assign pend = req_q & ena_q[NUM_SRC-1:0] & {NUM_SRC{ena_q[MASTER_BIT]}};

  irq_lvl_enc u_enc (.pend_i(pend), .lvl_o(lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ipl_no <= '1;
    else         ipl_no <= ~lvl;
  end

  assign ena_rdata_o = DATA_W'(ena_q);
  assign req_rdata_o = DATA_W'(req_q);

  p_master_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_q[MASTER_BIT] |=> (ipl_no == '1));

  p_soft_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q[SOFT_BIT]) |-> $past(req_wr_i && req_wdata_i[CTRL_BIT]));

  p_idle_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q == '0) |=> (ipl_no == '1));

  p_no_level7_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipl_no != '0);
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ena_wr = 1'b0, req_wr = 1'b0;
  logic [15:0] ena_wd = '0, req_wd = '0;
  logic [13:0] pulse = '0;
  logic [15:0] ena_rd, req_rd;
  logic [2:0]  ipl_n;

  int checks = 0, fails = 0;
  logic [14:0] ena_m = '0;
  logic [13:0] req_m = '0;
  logic [2:0]  ipl_m = 3'b111;

  always #5 clk = ~clk;

  irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ena_wr_i(ena_wr), .ena_wdata_i(ena_wd),
    .req_wr_i(req_wr), .req_wdata_i(req_wd), .src_pulse_i(pulse),
    .ena_rdata_o(ena_rd), .req_rdata_o(req_rd), .ipl_no(ipl_n)
  );

  function automatic int lvl_of(int i);
    if (i < 3) return 1;
    if (i == 3) return 2;
    if (i < 7) return 3;
    if (i < 11) return 4;
    if (i < 13) return 5;
    return 6;
  endfunction

  function automatic logic [2:0] exp_ipl(logic [14:0] e, logic [13:0] r);
    int best = 0;
    if (e[14])
      for (int i = 0; i < 14; i++)
        if (e[i] && r[i] && lvl_of(i) > best) best = lvl_of(i);
    return ~3'(best);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model at posedge, sample at next negedge
  task automatic cyc(logic ew, logic [15:0] ed, logic rw, logic [15:0] rd, logic [13:0] p);
    ena_wr = ew; ena_wd = ed; req_wr = rw; req_wd = rd; pulse = p;
    @(posedge clk);
    ipl_m = exp_ipl(ena_m, req_m);
    if (ew) ena_m = ed[15] ? (ena_m | ed[14:0]) : (ena_m & ~ed[14:0]);
    if (rw) req_m = rd[15] ? (req_m | rd[13:0]) : (req_m & ~rd[13:0]);
    req_m = req_m | (p & ~14'h0004);
    @(negedge clk);
    ena_wr = 0; req_wr = 0; pulse = '0;
  endtask

  task automatic check_all(string tag);
    check({tag, " ena"}, ena_rd, {1'b0, ena_m});
    check({tag, " req"}, req_rd, {2'b00, req_m});
    check({tag, " ipl"}, {13'd0, ipl_n}, {13'd0, ipl_m});
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1 ena", ena_rd, 16'h0000);
    check("R1 req", req_rd, 16'h0000);
    check("R1 ipl", {13'd0, ipl_n}, 16'h0007);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: set write, bit 15 not stored
    cyc(1, 16'hC020, 0, 0, 0);
    check("R2 set", ena_rd, 16'h4020);
    // R10: request upper bits read zero
    cyc(0, 0, 1, 16'hFFFF, 0);
    check("R10 req upper", req_rd, 16'h3FFF);
    cyc(0, 0, 0, 0, 0);
    check("R9 vb level3", {13'd0, ipl_n}, {13'd0, 3'b100});
    // R3: clear only bit 5
    cyc(0, 0, 1, 16'h0020, 0);
    check("R3 clear vb", req_rd, 16'h3FDF);
    cyc(0, 0, 1, 16'h3FFF, 0);
    check("R3 clear all", req_rd, 16'h0000);
    // R5: soft bit pulse ignored
    cyc(0, 0, 0, 0, 14'h0004);
    check("R5 soft pulse", req_rd, 16'h0000);
    cyc(0, 0, 1, 16'h8004, 0);
    check("R5 soft write", req_rd, 16'h0004);
    // R4: pulse latches with enable off
    cyc(0, 0, 0, 0, 14'h2000);
    check("R4 latch", req_rd, 16'h2004);
    cyc(0, 0, 0, 0, 0);
    check("R4 hold", req_rd, 16'h2004);
    // R6: pulse beats clear
    cyc(0, 0, 1, 16'h2000, 14'h2000);
    check("R6 set wins", req_rd, 16'h2004);
    // R7: master off blocks level
    cyc(1, 16'hBFFF, 0, 0, 0);
    cyc(1, 16'h4000, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check("R7 master off", {13'd0, ipl_n}, 16'h0007);
    cyc(1, 16'hC000, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    check("R7 master on", {13'd0, ipl_n}, {13'd0, 3'b001});
    // R8: each source alone
    cyc(0, 0, 1, 16'h3FFF, 0);
    for (int i = 0; i < 14; i++) begin
      cyc(0, 0, 1, 16'h8000 | (16'd1 << i), 0);
      cyc(0, 0, 0, 0, 0);
      check("R8 map", {13'd0, ipl_n}, {13'd0, ~3'(lvl_of(i))});
      cyc(0, 0, 1, 16'd1 << i, 0);
    end
    // R9: masked high source, lower enabled
    cyc(1, 16'h2000, 1, 16'hA080, 0);
    cyc(0, 0, 0, 0, 0);
    check("R9 masked high", {13'd0, ipl_n}, {13'd0, 3'b011});

    for (int n = 0; n < 3000; n++) begin
      logic ew, rw;
      logic [15:0] ed, rd;
      logic [13:0] p;
      ew = ($urandom % 6) == 0;
      rw = ($urandom % 3) == 0;
      ed = 16'($urandom);
      if ($urandom % 4 != 0) ed[15] = 1'b1;
      rd = 16'($urandom);
      p  = (($urandom % 4) == 0) ? 14'(16'd1 << ($urandom % 14)) : 14'd0;
      if (n % 97 == 0) begin rw = 1; rd = 16'h3FFF; p = 14'h3FFF; end
      cyc(ew, ed, rw, rd, p);
      check_all("R4 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule